// File: doc/BRIEF.md
# Neighbor-Index Property Address Generator

This block sits beside the memory controller and looks at every cache line coming back from DRAM. Most refills pass by untouched. A refill whose request was tagged as an adjacency-list prefetch is taken apart instead. The 64-byte line is read as a packed array of vertex indices. Every index is scaled by the 4-byte size of a property element and added to a configured base. The resulting virtual addresses are queued, each with the core ID of the requester, for a downstream translation stage.

Both the refill input and the address output are valid/ready streams. `line_ready` is high only while the unit is idle. A line is taken on any cycle where `line_valid` and `line_ready` are both high. Untagged lines are taken and ignored. The refill path is never stalled by the output queue: a tagged line that will not fit in the queue is discarded whole, and a counter records it. The output side follows the usual rule. `out_vaddr` and `out_core` stay put until `out_ready` pops them. A consumer may hold `out_ready` low for as long as it likes.

The base address and the entry width are plain configuration inputs. They are sampled on the cycle a line is accepted.

Top module: `nbr_prop_agen`

## Requirements
- R1: `line_ready` is 1 exactly when no accepted line is still in flight. An untagged line (`line_tag`=0) is accepted and produces no output, and `line_ready` stays 1 after it.
- R2: With `cfg_wide`=0, an accepted tagged line yields 16 addresses. Address number i (i = 0..15) takes its index from `line_data[32*i+31:32*i]`. The addresses enter the queue in ascending i.
- R3: With `cfg_wide`=1, an accepted tagged line yields 8 addresses. Address number j (j = 0..7) takes its index from `line_data[64*j+31:64*j]`. The upper 32 bits of each 64-bit entry have no effect.
- R4: Each address equals `cfg_base` + 4 × index, with the index zero-extended to 64 bits and the sum taken modulo 2^64. `cfg_base` and `cfg_wide` are sampled at the acceptance edge, so later changes do not affect a line already taken.
- R5: Every address produced from a line carries that line's `line_core` on `out_core`.
- R6: The first addresses of a line appear at the queue output after the second rising edge following the acceptance edge. At most 4 addresses are enqueued per cycle. `line_ready` returns to 1 after the edge that enqueues the last address.
- R7: The output queue holds 512 entries and keeps the order of insertion. While `out_valid`=1 and `out_ready`=0, the head entry is held unchanged.
- R8: A tagged line is dropped if, at acceptance, the queue has fewer free entries than the line would produce. A dropped line enqueues nothing, `drop_count` increases by one (saturating), and `line_ready` stays 1.
- R9: After reset, `line_ready`=1, `out_valid`=0 and `drop_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Refill line present |
| line_ready | output | 1 | Unit idle, line will be taken |
| line_data | input | 512 | Refill line payload, byte 0 in bits 7:0 |
| line_tag | input | 1 | 1 = line returns an adjacency-list prefetch |
| line_core | input | 4 | Core that issued the prefetch |
| cfg_base | input | 64 | Virtual base of the property array |
| cfg_wide | input | 1 | 0 = 4-byte index entries, 1 = 8-byte entries (index in low half) |
| out_valid | output | 1 | Queue head valid |
| out_ready | input | 1 | Consumer pops the head |
| out_vaddr | output | 64 | Property element virtual address |
| out_core | output | 4 | Core ID attached to the address |
| drop_count | output | 16 | Saturating count of discarded tagged lines |

## Verification
The assertions assume that the inputs follow the stream rules: `line_valid` and the refill fields are known whenever they are sampled, and `out_ready` is never X. They also assume the drop counter is not at its maximum when a drop is checked; the property that links a tagged handshake to either busy or a drop excludes the saturated case explicitly. The stimulus changes inputs only on falling edges and holds a line on the port until the handshake. It never sends more lines than can saturate the 16-bit counter. The back-pressure patterns on `out_ready` are random or fixed, but always binary, so every assumption holds throughout the run.

// File: rtl/npa_pkg.sv
package npa_pkg;
  localparam int ADDR_W = 64;
  localparam int CORE_W = 4;

  typedef logic [ADDR_W-1:0] vaddr_t;

  typedef struct packed {
    vaddr_t            vaddr;
    logic [CORE_W-1:0] core;
  } vent_t;
endpackage

// File: rtl/npa_scan.sv
// Two-stage line scanner: stage A captures an accepted tagged line together
// with its configuration; stage B holds every lane's finished address.
module npa_scan
  import npa_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int IDX_BYTES  = 4,
  parameter int ELEM_SHIFT = 2,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int IDX_W  = IDX_BYTES * 8,
  localparam int NLANE  = LINE_BYTES / IDX_BYTES,
  localparam int NWIDE  = NLANE / 2,
  localparam int CNT_W  = $clog2(NLANE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] line_data,
  input  logic              wide,
  input  vaddr_t            base,
  input  logic [CORE_W-1:0] core,
  input  logic              retire,
  output logic              busy,
  output logic              b_vld,
  output vaddr_t            b_addr [NLANE],
  output logic [CNT_W-1:0]  b_cnt,
  output logic [CORE_W-1:0] b_core
);

  logic              a_vld;
  logic [LINE_W-1:0] a_line;
  logic              a_wide;
  vaddr_t            a_base;
  logic [CORE_W-1:0] a_core;
  vaddr_t            lane_addr [NLANE];

  always_ff @(posedge clk) begin
    if (!rst_n) a_vld <= 1'b0;
    else        a_vld <= load;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_line <= line_data;
      a_wide <= wide;
      a_base <= base;
      a_core <= core;
    end
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [IDX_W-1:0] narrow_idx;
    logic [IDX_W-1:0] wide_idx;
    logic [IDX_W-1:0] sel_idx;
    assign narrow_idx = a_line[i*IDX_W +: IDX_W];
    if (i < NWIDE) begin : g_wide
      assign wide_idx = a_line[2*i*IDX_W +: IDX_W];
    end else begin : g_nowide
      assign wide_idx = '0;
    end
    assign sel_idx      = a_wide ? wide_idx : narrow_idx;
    assign lane_addr[i] = a_base + (vaddr_t'(sel_idx) << ELEM_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      b_vld <= 1'b0;
    else if (a_vld)  b_vld <= 1'b1;
    else if (retire) b_vld <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (a_vld) begin
      for (int i = 0; i < NLANE; i++) b_addr[i] <= lane_addr[i];
      b_cnt  <= a_wide ? CNT_W'(NWIDE) : CNT_W'(NLANE);
      b_core <= a_core;
    end
  end

  assign busy = a_vld | b_vld;

endmodule

// File: rtl/npa_drain.sv
// Walks the stage-B address vector in chunks of PUSH_W per cycle.
module npa_drain
  import npa_pkg::*;
#(
  parameter int NLANE  = 16,
  parameter int PUSH_W = 4,
  localparam int CNT_W  = $clog2(NLANE + 1),
  localparam int PN_W   = $clog2(PUSH_W + 1),
  localparam int NCHUNK = (NLANE + PUSH_W - 1) / PUSH_W,
  localparam int CH_W   = $clog2(NCHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_vld,
  input  vaddr_t            b_addr [NLANE],
  input  logic [CNT_W-1:0]  b_cnt,
  input  logic [CORE_W-1:0] b_core,
  output logic [PN_W-1:0]   push_n,
  output vent_t             push_ent [PUSH_W],
  output logic              retire
);

  logic [CH_W-1:0] ch;

  always_ff @(posedge clk) begin
    if (!rst_n)      ch <= '0;
    else if (retire) ch <= '0;
    else if (b_vld)  ch <= ch + 1'b1;
  end

  always_comb begin
    int first;
    int left;
    first = int'(ch) * PUSH_W;
    left  = int'(b_cnt) - first;
    for (int k = 0; k < PUSH_W; k++) begin
      push_ent[k].core  = b_core;
      push_ent[k].vaddr = '0;
      if (first + k < NLANE) push_ent[k].vaddr = b_addr[first + k];
    end
    if (!b_vld)              push_n = '0;
    else if (left < PUSH_W)  push_n = PN_W'(left);
    else                     push_n = PN_W'(PUSH_W);
    retire = b_vld && (left <= PUSH_W);
  end

endmodule

// File: rtl/npa_vfifo.sv
// Address queue with up to PUSH_W writes and one read per cycle.
module npa_vfifo
  import npa_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int PUSH_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PN_W  = $clog2(PUSH_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PN_W-1:0]  push_n,
  input  vent_t            push_ent [PUSH_W],
  input  logic             pop_ready,
  output logic             head_vld,
  output vent_t            head,
  output logic [LVL_W-1:0] level
);

  vent_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             pop;

  assign head_vld = (level != '0);
  assign head     = mem[rd_ptr];
  assign pop      = head_vld & pop_ready;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_W; k++) begin
      if (PN_W'(k) < push_n) mem[wr_ptr + PTR_W'(k)] <= push_ent[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      level  <= level + LVL_W'(push_n) - LVL_W'(pop);
    end
  end

endmodule

// File: rtl/nbr_prop_agen.sv
module nbr_prop_agen
  import npa_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int IDX_BYTES  = 4,
  parameter int ELEM_SHIFT = 2,
  parameter int FIFO_DEPTH = 512,
  parameter int PUSH_W     = 4,
  parameter int DROP_W     = 16,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int NLANE  = LINE_BYTES / IDX_BYTES,
  localparam int NWIDE  = NLANE / 2,
  localparam int CNT_W  = $clog2(NLANE + 1),
  localparam int PN_W   = $clog2(PUSH_W + 1),
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_valid,
  output logic              line_ready,
  input  logic [LINE_W-1:0] line_data,
  input  logic              line_tag,
  input  logic [CORE_W-1:0] line_core,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_vaddr,
  output logic [CORE_W-1:0] out_core,
  output logic [DROP_W-1:0] drop_count
);

  logic              busy;
  logic              accept;
  logic              room;
  logic              load;
  logic              drop_ev;
  logic [LVL_W-1:0]  level;
  logic [LVL_W-1:0]  need;
  logic              b_vld;
  vaddr_t            b_addr [NLANE];
  logic [CNT_W-1:0]  b_cnt;
  logic [CORE_W-1:0] b_core;
  logic              retire;
  logic [PN_W-1:0]   push_n;
  vent_t             push_ent [PUSH_W];
  vent_t             head;

  assign line_ready = ~busy;
  assign accept     = line_valid & line_ready;
  assign need       = cfg_wide ? LVL_W'(NWIDE) : LVL_W'(NLANE);
  assign room       = (LVL_W'(FIFO_DEPTH) - level) >= need;
  assign load       = accept & line_tag & room;
  assign drop_ev    = accept & line_tag & ~room;

  npa_scan #(
    .LINE_BYTES(LINE_BYTES),
    .IDX_BYTES (IDX_BYTES),
    .ELEM_SHIFT(ELEM_SHIFT)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .line_data(line_data),
    .wide     (cfg_wide),
    .base     (cfg_base),
    .core     (line_core),
    .retire   (retire),
    .busy     (busy),
    .b_vld    (b_vld),
    .b_addr   (b_addr),
    .b_cnt    (b_cnt),
    .b_core   (b_core)
  );

  npa_drain #(
    .NLANE (NLANE),
    .PUSH_W(PUSH_W)
  ) u_drain (
    .clk     (clk),
    .rst_n   (rst_n),
    .b_vld   (b_vld),
    .b_addr  (b_addr),
    .b_cnt   (b_cnt),
    .b_core  (b_core),
    .push_n  (push_n),
    .push_ent(push_ent),
    .retire  (retire)
  );

  npa_vfifo #(
    .DEPTH (FIFO_DEPTH),
    .PUSH_W(PUSH_W)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (push_n),
    .push_ent (push_ent),
    .pop_ready(out_ready),
    .head_vld (out_valid),
    .head     (head),
    .level    (level)
  );

  assign out_vaddr = head.vaddr;
  assign out_core  = head.core;

  always_ff @(posedge clk) begin
    if (!rst_n)                             drop_count <= '0;
    else if (drop_ev && drop_count != '1)   drop_count <= drop_count + 1'b1;
  end

endmodule

// File: rtl/npa_checker.sv
module npa_checker
  import npa_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_valid,
  input logic              line_ready,
  input logic              line_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_vaddr,
  input logic [CORE_W-1:0] out_core,
  input logic [DROP_W-1:0] drop_count
);

  p_untag_keeps_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_ready && !line_tag) |=> line_ready);

  p_tag_busy_or_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_ready && line_tag) |=>
      (!line_ready || drop_count != $past(drop_count) || $past(drop_count) == '1));

  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_vaddr) && $stable(out_core)));

  p_drop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(line_valid && line_ready && line_tag));

  p_drop_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count >= $past(drop_count));

endmodule

bind nbr_prop_agen npa_checker #(.DROP_W(DROP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_valid(line_valid),
  .line_ready(line_ready),
  .line_tag  (line_tag),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vaddr (out_vaddr),
  .out_core  (out_core),
  .drop_count(drop_count)
);

// File: tb/nbr_prop_agen_tb_top.sv
`timescale 1ns/1ps
module nbr_prop_agen_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         line_valid;
  logic         line_ready;
  logic [511:0] line_data;
  logic         line_tag;
  logic [3:0]   line_core;
  logic [63:0]  cfg_base;
  logic         cfg_wide;
  logic         out_valid;
  logic         out_ready;
  logic [63:0]  out_vaddr;
  logic [3:0]   out_core;
  logic [15:0]  drop_count;

  always #2.5 clk = ~clk;

  nbr_prop_agen dut_i (
    .clk(clk), .rst_n(rst_n),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data),
    .line_tag(line_tag), .line_core(line_core),
    .cfg_base(cfg_base), .cfg_wide(cfg_wide),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vaddr(out_vaddr), .out_core(out_core), .drop_count(drop_count)
  );

  typedef struct {
    logic [63:0] a;
    logic [3:0]  c;
  } ent_t;

  ent_t  mq[$];
  ent_t  pend[$];
  int    phase;
  int    mdrop;
  bit    acc_last;
  int    nchk;
  int    nerr;
  string cur_tag;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: state after one rising edge, from inputs held before it.
  task automatic model_step();
    int sz0 = mq.size();
    int ph0 = phase;
    acc_last = 1'b0;
    if (out_ready && sz0 > 0) void'(mq.pop_front());
    if (ph0 == 2) begin
      for (int k = 0; k < 4 && pend.size() > 0; k++) mq.push_back(pend.pop_front());
      if (pend.size() == 0) phase = 0;
    end
    if (ph0 == 1) phase = 2;
    if (ph0 == 0 && line_valid) begin
      acc_last = 1'b1;
      if (line_tag) begin
        int n = cfg_wide ? 8 : 16;
        if (512 - sz0 >= n) begin
          for (int j = 0; j < n; j++) begin
            logic [31:0] idx;
            ent_t e;
            idx = cfg_wide ? line_data[64*j +: 32] : line_data[32*j +: 32];
            e.a = cfg_base + ({32'b0, idx} << 2);
            e.c = line_core;
            pend.push_back(e);
          end
          phase = 1;
        end else if (mdrop < 65535) begin
          mdrop++;
        end
      end
    end
  endtask

  task automatic compare();
    chk(line_ready == (phase == 0), "R1", 64'(line_ready), 64'(phase == 0));
    chk(out_valid == (mq.size() > 0), cur_tag, 64'(out_valid), 64'(mq.size() > 0));
    if (mq.size() > 0 && out_valid) begin
      chk(out_vaddr == mq[0].a, cur_tag, out_vaddr, mq[0].a);
      chk(out_core == mq[0].c, "R5", 64'(out_core), 64'(mq[0].c));
    end
    chk(drop_count == 16'(mdrop), "R8", 64'(drop_count), 64'(mdrop));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic send_line(input bit tag, input bit wide);
    for (int w = 0; w < 16; w++) line_data[32*w +: 32] = $urandom;
    line_tag   = tag;
    cfg_wide   = wide;
    line_core  = 4'($urandom);
    line_valid = 1'b1;
    do tick(); while (!acc_last);
    line_valid = 1'b0;
  endtask

  task automatic drain_all();
    out_ready = 1'b1;
    while (mq.size() > 0 || phase != 0) tick();
  endtask

  initial begin
    nchk = 0; nerr = 0; phase = 0; mdrop = 0; cur_tag = "R9";
    rst_n = 1'b0; line_valid = 1'b0; line_data = '0; line_tag = 1'b0;
    line_core = '0; cfg_base = 64'h0000_1000_0000_0000; cfg_wide = 1'b0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk(line_ready == 1'b1, "R9", 64'(line_ready), 64'd1);
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    chk(drop_count == 16'd0, "R9", 64'(drop_count), 64'd0);
    tick();

    // R1: untagged lines produce nothing and keep ready high
    cur_tag = "R1";
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) send_line(1'b0, i[0]);
    repeat (4) tick();

    // R2: narrow entries
    cur_tag = "R2";
    cfg_base = {$urandom, $urandom};
    for (int i = 0; i < 4; i++) send_line(1'b1, 1'b0);
    drain_all();

    // R3: wide entries, upper halves ignored
    cur_tag = "R3";
    for (int i = 0; i < 4; i++) send_line(1'b1, 1'b1);
    drain_all();

    // R4: wrap-around sum, config changed right after acceptance
    cur_tag = "R4";
    cfg_base = 64'hFFFF_FFFF_FFFF_FF00;
    send_line(1'b1, 1'b0);
    cfg_base = 64'h0;
    cfg_wide = 1'b1;
    drain_all();
    cfg_base = 64'hFFFF_FFFF_0000_0004;
    line_data = '1;
    line_tag = 1'b1; cfg_wide = 1'b1; line_core = 4'hA; line_valid = 1'b1;
    do tick(); while (!acc_last);
    line_valid = 1'b0;
    cfg_base = 64'h5;
    drain_all();

    // R6: single line from idle, latency and chunking
    cur_tag = "R6";
    repeat (3) tick();
    send_line(1'b1, 1'b0);
    drain_all();
    send_line(1'b1, 1'b1);
    drain_all();

    // R7: random back-pressure, mixed lines, head holding
    cur_tag = "R7";
    for (int i = 0; i < 20; i++) begin
      out_ready = 1'($urandom);
      line_tag = 1'b1;
      for (int w = 0; w < 16; w++) line_data[32*w +: 32] = $urandom;
      cfg_wide = 1'($urandom);
      line_core = 4'($urandom);
      line_valid = 1'b1;
      do begin
        out_ready = 1'($urandom);
        tick();
      end while (!acc_last);
      line_valid = 1'b0;
      repeat (3) begin
        out_ready = 1'($urandom);
        tick();
      end
    end
    drain_all();

    // R8: fill the queue, then lines that do not fit are dropped
    cur_tag = "R8";
    out_ready = 1'b0;
    for (int i = 0; i < 32; i++) send_line(1'b1, 1'b0);
    repeat (6) tick();
    send_line(1'b1, 1'b0);
    tick();
    send_line(1'b1, 1'b1);
    tick();
    out_ready = 1'b1;
    repeat (8) tick();
    out_ready = 1'b0;
    send_line(1'b1, 1'b1);
    repeat (6) tick();
    send_line(1'b1, 1'b0);
    tick();
    drain_all();
    chk(drop_count == 16'd3, "R8", 64'(drop_count), 64'd3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule